// File: doc/BRIEF.md
# Multi-Slot Codec Serial Port

This block is a frame-synchronous serial port for audio codecs and data converters. It moves words between a small shadow buffer and one 16-bit shift register, most significant bit first, over a serial clock, a frame sync line, a serial data output with its own enable and a serial data input. Each frame is divided into up to 16 time slots. Each slot lasts one word of programmable length and can be enabled or skipped on its own. The clock and the frame sync can each be generated inside the block or taken from an external device.

The parallel side has a register port with four transmit words and four receive words. A single 2-bit pointer walks the shadow buffer. After every fourth enabled slot, a buffer-full event does three things at once: it copies the four received words into the readable registers, it reloads the transmit shadow from the writable registers, and it raises a one-cycle pulse. Software therefore gets a whole group-time to read results and to stage the next four words. A sticky flag reports when a group was lost because the previous one was not read.

The pin enables are outputs of the block. A pad ring, or a testbench, turns each `_o`/`_oe` pair into a real tri-state pin.

Top module: `codec_serial_port`

## Requirements
- R1: After reset, `sck_oe`, `fs_oe`, `sdo_oe`, `buf_full`, `rx_ovf` and `reg_rdata` are all 0.
- R2: When enabled with `cfg_clk_master`=1, `sck_oe` is 1. `sck_o` then has a period of 2*(`cfg_div`+1) system clock cycles.
- R3: With generated sync, `fs_o` is high for exactly one bit period. That bit period is the last bit of the previous frame, or the idle bit that follows enabling. Slot 0's first bit follows it. A frame lasts (`cfg_last_slot`+1)*(word length) bit periods.
- R4: The word length is `cfg_word_len`+1 bits, for `cfg_word_len` in 3..15. Words are sent most significant bit first from bit 15 of the buffer word. Data changes after a falling clock edge and is sampled on the rising edge. Transmit bits below the word length are never sent.
- R5: In a received word, the bits below the word length read as 0.
- R6: During a bit of a disabled slot (`cfg_slot_en[slot]`=0), or outside a frame, `sdo_oe` equals `cfg_idle_low` and `sdo_o` is 0. During enabled slots, `sdo_oe` is 1.
- R7: Enabled slots use buffer index 0,1,2,3 in turn for both directions, whatever slots they occupy. The received word at index i comes from the slot that sent transmit word i. After the fourth such slot, `buf_full` pulses for one cycle and the index returns to 0.
- R8: Transmit words written while enabled are used only from the group that starts after the next `buf_full`. Receive registers change only at `buf_full`. While disabled, the transmit shadow follows the transmit registers.
- R9: `rx_ovf` sets at a `buf_full` that comes while the previous group is unread, and stays set until the block is disabled. A group is unread until receive index 3 is read.
- R10: With `cfg_clk_master`=0 and `cfg_fs_master`=0, both enables are 0. The block then frames and receives on the externally supplied `sck_i`/`fs_i`, after passing them through two synchronizer stages.
- R11: `reg_addr[2]` selects transmit (1) or receive (0), and `reg_addr[1:0]` selects the index. A read returns data on the cycle after `reg_rd`. Writes to receive addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low clears framing, pointer and flags |
| cfg_clk_master | input | 1 | 1: generate bit clock, 0: use sck_i |
| cfg_fs_master | input | 1 | 1: generate frame sync, 0: use fs_i |
| cfg_idle_low | input | 1 | 1: drive 0 in unused bit periods, 0: release output |
| cfg_div | input | 8 | Half bit period minus one, in system clocks |
| cfg_word_len | input | 4 | Word length minus one |
| cfg_last_slot | input | 4 | Slots per frame minus one |
| cfg_slot_en | input | 16 | Per-slot enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | {direction, index} |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after reg_rd |
| buf_full | output | 1 | One-cycle pulse per completed group of four words |
| rx_ovf | output | 1 | Sticky receive overflow |
| sck_i | input | 1 | External bit clock |
| sck_o | output | 1 | Generated bit clock |
| sck_oe | output | 1 | Bit clock output enable |
| fs_i | input | 1 | External frame sync |
| fs_o | output | 1 | Generated frame sync |
| fs_oe | output | 1 | Frame sync output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
The assertions watch several properties on every cycle. Rising and falling bit events must never coincide. A sampled sync must put the frame counters at slot 0, bit 0. The pointer must be back at 0 when the group pulse fires. The overflow flag must stay set. The data line must stay low whenever it is driven outside an enabled slot. Other behaviours only show in the bench scenarios. These include the loopback of whole words at random word lengths and slot patterns, the one-group delay of newly written transmit words, and the sync position within each frame. They also include the clock period, overflow after two unread groups, and reception on external clock and sync.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = $clog2(WORD_W);
  localparam int MIN_LEN_M1 = 3;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LEN_W-1:0]  len_t;

  // shortest supported word is MIN_LEN_M1+1 bits
  function automatic len_t eff_len(input len_t wl_m1);
    return (wl_m1 < len_t'(MIN_LEN_M1)) ? len_t'(MIN_LEN_M1) : wl_m1;
  endfunction

  // move the received bits to the top, zeros below
  function automatic word_t align_rx(input word_t sr, input len_t wl_m1);
    len_t sh;
    sh = len_t'(WORD_W - 1) - wl_m1;
    return sr << sh;
  endfunction
endpackage

// File: rtl/csp_bitclk.sv
module csp_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             master,
  input  logic [DIV_W-1:0] div,
  input  logic             sck_i,
  input  logic             fs_i,
  input  logic             sdi_i,
  output logic             sck_o,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             fs_ext,
  output logic             sdi_ext
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q, m_rise_q, m_fall_q;
  logic [2:0]       ck_sync;
  logic [1:0]       fs_sync, di_sync;
  logic             s_rise, s_fall;

  // generated clock: toggle every div+1 cycles
  always_ff @(posedge clk) begin
    if (rst || !en || !master) begin
      cnt_q    <= '0;
      sck_q    <= 1'b0;
      m_rise_q <= 1'b0;
      m_fall_q <= 1'b0;
    end else begin
      m_rise_q <= 1'b0;
      m_fall_q <= 1'b0;
      if (cnt_q == div) begin
        cnt_q    <= '0;
        sck_q    <= ~sck_q;
        m_rise_q <= ~sck_q;
        m_fall_q <= sck_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // external clock, sync and data share the same two-stage delay
  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sync <= '0;
      fs_sync <= '0;
      di_sync <= '0;
    end else begin
      ck_sync <= {ck_sync[1:0], sck_i};
      fs_sync <= {fs_sync[0], fs_i};
      di_sync <= {di_sync[0], sdi_i};
    end
  end

  assign s_rise   = ck_sync[1] & ~ck_sync[2];
  assign s_fall   = ~ck_sync[1] & ck_sync[2];
  assign rise_evt = en & (master ? m_rise_q : s_rise);
  assign fall_evt = en & (master ? m_fall_q : s_fall);
  assign fs_ext   = fs_sync[1];
  assign sdi_ext  = di_sync[1];
  assign sck_o    = sck_q;

  p_edge_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(rise_evt && fall_evt));
endmodule

// File: rtl/csp_frame.sv
module csp_frame
  import csp_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rise,
  input  logic              fall,
  input  logic              fs_master,
  input  logic              fs_ext,
  input  len_t              wl_m1,
  input  logic [SLOT_W-1:0] last_slot,
  input  logic [NSLOT-1:0]  slot_en,
  output logic              fs_o,
  output logic              active_o,
  output logic              active_n_o,
  output logic              load_o,
  output logic              done_o
);
  logic              run_q, run_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  len_t              bit_q, bit_n, wl;
  logic              fs_q, fs_seen_q;
  logic              cur_en, nxt_en, frame_end_n;

  assign wl = eff_len(wl_m1);

  // position of the bit that starts at this falling edge
  always_comb begin
    run_n  = run_q;
    slot_n = slot_q;
    bit_n  = bit_q;
    if (fs_seen_q) begin
      run_n  = 1'b1;
      slot_n = '0;
      bit_n  = '0;
    end else if (run_q) begin
      if (bit_q >= wl) begin
        bit_n = '0;
        if (slot_q >= last_slot) run_n = 1'b0;
        else                     slot_n = slot_q + 1'b1;
      end else begin
        bit_n = bit_q + 1'b1;
      end
    end
  end

  assign frame_end_n = run_n && (slot_n >= last_slot) && (bit_n >= wl);
  assign cur_en      = run_q & slot_en[slot_q];
  assign nxt_en      = run_n & slot_en[slot_n];

  assign done_o     = fall & cur_en & (bit_q >= wl);
  assign load_o     = fall & nxt_en & (bit_n == '0);
  assign active_o   = cur_en;
  assign active_n_o = nxt_en;
  assign fs_o       = fs_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_q     <= 1'b0;
      slot_q    <= '0;
      bit_q     <= '0;
      fs_q      <= 1'b0;
      fs_seen_q <= 1'b0;
    end else begin
      if (rise) fs_seen_q <= fs_master ? fs_q : fs_ext;
      if (fall) begin
        run_q  <= run_n;
        slot_q <= slot_n;
        bit_q  <= bit_n;
        fs_q   <= !run_n || frame_end_n;
      end
    end
  end

  p_fs_start_r3: assert property (@(posedge clk) disable iff (rst || !en)
    (fall && fs_seen_q) |=> (run_q && slot_q == '0 && bit_q == '0));
endmodule

// File: rtl/csp_buffer.sv
module csp_buffer
  import csp_pkg::*;
#(
  parameter int PTR_W  = 2,
  parameter int ADDR_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              done,
  input  word_t             rx_word,
  output word_t             tx_word,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  word_t             reg_wdata,
  output word_t             reg_rdata,
  output logic              buf_full,
  output logic              rx_ovf
);
  localparam int DEPTH = 1 << PTR_W;

  word_t            shadow [2*DEPTH];
  word_t            cpu_tx [DEPTH];
  word_t            cpu_rx [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_nx, idx;
  logic             grp_end, pend_q, rd_last, pend_live;

  assign idx     = reg_addr[PTR_W-1:0];
  assign grp_end = done && (ptr_q == PTR_W'(DEPTH-1));
  assign ptr_nx  = done ? ptr_q + 1'b1 : ptr_q;
  // at a wrap the shadow is being refilled; forward the new word 0
  assign tx_word = grp_end ? cpu_tx[0] : shadow[{1'b1, ptr_nx}];
  assign rd_last = reg_rd && !reg_addr[PTR_W] && (idx == PTR_W'(DEPTH-1));
  assign pend_live = pend_q && !rd_last;

  // shadow words: receive half at {0,ptr}, transmit half at {1,ptr}
  always_ff @(posedge clk) begin
    if (!en) begin
      for (int i = 0; i < DEPTH; i++) shadow[DEPTH+i] <= cpu_tx[i];
    end else if (done) begin
      shadow[{1'b0, ptr_q}] <= rx_word;
      if (grp_end)
        for (int i = 0; i < DEPTH; i++) shadow[DEPTH+i] <= cpu_tx[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        cpu_tx[i] <= '0;
        cpu_rx[i] <= '0;
      end
      ptr_q     <= '0;
      pend_q    <= 1'b0;
      rx_ovf    <= 1'b0;
      buf_full  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      buf_full <= 1'b0;
      if (reg_wr && reg_addr[PTR_W]) cpu_tx[idx] <= reg_wdata;
      if (reg_rd) reg_rdata <= reg_addr[PTR_W] ? cpu_tx[idx] : cpu_rx[idx];
      if (!en) begin
        ptr_q  <= '0;
        pend_q <= 1'b0;
        rx_ovf <= 1'b0;
      end else begin
        ptr_q <= ptr_nx;
        if (rd_last) pend_q <= 1'b0;
        if (grp_end) begin
          for (int i = 0; i < DEPTH; i++)
            cpu_rx[i] <= (i == DEPTH-1) ? rx_word : shadow[i];
          pend_q   <= 1'b1;
          buf_full <= 1'b1;
          if (pend_live) rx_ovf <= 1'b1;
        end
      end
    end
  end

  p_group_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    buf_full |-> (ptr_q == '0));
  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (rst || !en)
    rx_ovf |=> rx_ovf);
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import csp_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int NSLOT  = 16,
  parameter int PTR_W  = 2,
  parameter int SLOT_W = $clog2(NSLOT),
  parameter int ADDR_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cfg_clk_master,
  input  logic              cfg_fs_master,
  input  logic              cfg_idle_low,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_word_len,
  input  logic [SLOT_W-1:0] cfg_last_slot,
  input  logic [NSLOT-1:0]  cfg_slot_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              buf_full,
  output logic              rx_ovf,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              fs_i,
  output logic              fs_o,
  output logic              fs_oe,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe
);
  logic  rise, fall, fs_ext, sdi_ext, sdi_s;
  logic  active, active_n, load, done;
  word_t sr_q, tx_word, rx_word;

  csp_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .en(en), .master(cfg_clk_master), .div(cfg_div),
    .sck_i(sck_i), .fs_i(fs_i), .sdi_i(sdi_i), .sck_o(sck_o),
    .rise_evt(rise), .fall_evt(fall), .fs_ext(fs_ext), .sdi_ext(sdi_ext)
  );

  csp_frame #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_frame (
    .clk(clk), .rst(rst), .en(en), .rise(rise), .fall(fall),
    .fs_master(cfg_fs_master), .fs_ext(fs_ext), .wl_m1(cfg_word_len),
    .last_slot(cfg_last_slot), .slot_en(cfg_slot_en), .fs_o(fs_o),
    .active_o(active), .active_n_o(active_n), .load_o(load), .done_o(done)
  );

  csp_buffer #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst(rst), .en(en), .done(done), .rx_word(rx_word),
    .tx_word(tx_word), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_full(buf_full),
    .rx_ovf(rx_ovf)
  );

  assign sdi_s   = cfg_clk_master ? sdi_i : sdi_ext;
  assign rx_word = align_rx(sr_q, eff_len(cfg_word_len));

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_oe <= 1'b0;
      fs_oe  <= 1'b0;
    end else begin
      sck_oe <= en & cfg_clk_master;
      fs_oe  <= en & cfg_fs_master;
    end
  end

  // one shift register: out of bit 15 on fall, in at bit 0 on rise
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sr_q   <= '0;
      sdo_o  <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      if (rise && active) sr_q <= {sr_q[WORD_W-2:0], sdi_s};
      if (fall) begin
        if (load) sr_q <= tx_word;
        sdo_o  <= load ? tx_word[WORD_W-1] : (active_n ? sr_q[WORD_W-1] : 1'b0);
        sdo_oe <= active_n | cfg_idle_low;
      end
    end
  end

  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && !active) |-> !sdo_o);
endmodule

// File: tb/codec_serial_port_test.sv
module codec_serial_port_test;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic cfg_clk_master = 1'b1, cfg_fs_master = 1'b1, cfg_idle_low = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic [3:0] cfg_word_len = 4'd7, cfg_last_slot = 4'd3;
  logic [15:0] cfg_slot_en = 16'h000F;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic buf_full, rx_ovf, sck_o, sck_oe, fs_o, fs_oe, sdo_o, sdo_oe, sdi_i;
  logic sck_drv = 1'b0, fs_drv = 1'b0, sdi_drv = 1'b0, loop = 1'b1;

  int n_chk = 0, n_fail = 0, evt_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign sdi_i = loop ? sdo_o : sdi_drv;

  codec_serial_port uut (
    .clk(clk), .rst(rst), .en(en), .cfg_clk_master(cfg_clk_master),
    .cfg_fs_master(cfg_fs_master), .cfg_idle_low(cfg_idle_low),
    .cfg_div(cfg_div), .cfg_word_len(cfg_word_len),
    .cfg_last_slot(cfg_last_slot), .cfg_slot_en(cfg_slot_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_full(buf_full),
    .rx_ovf(rx_ovf), .sck_i(sck_drv), .sck_o(sck_o), .sck_oe(sck_oe),
    .fs_i(fs_drv), .fs_o(fs_o), .fs_oe(fs_oe), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] keep_top(input logic [15:0] w, input int wl_m1);
    int e;
    e = (wl_m1 < 3) ? 3 : wl_m1;
    return w & ~(16'hFFFF >> (e + 1));
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  always @(negedge clk) if (buf_full) evt_cnt++;

  task automatic wait_evt();
    int target;
    target = evt_cnt + 1;
    for (int t = 0; t < 20000 && evt_cnt < target; t++) @(negedge clk);
    chk("R7 group event", int'(evt_cnt >= target), 1);
  endtask

  // ---- monitor of the generated frame, model built from R2/R3/R6 ----
  bit mon_on = 0, m_started = 0, m_prev = 0;
  int m_cyc = 0, m_last = -1, m_bpos = 0;
  int m_wl = 7, m_ls = 3, m_div = 1;
  logic [15:0] m_en = 16'h000F;
  logic m_idle = 1'b0;

  always @(negedge clk) begin
    if (!mon_on) begin
      m_started = 0; m_prev = 0; m_last = -1; m_cyc = 0; m_bpos = 0;
    end else begin
      m_cyc++;
      if (sck_o && !m_prev) begin
        if (m_last >= 0) chk("R2 sck period", m_cyc - m_last, 2 * (m_div + 1));
        m_last = m_cyc;
        if (m_started) begin
          int slot;
          bit ben;
          slot = m_bpos / (m_wl + 1);
          ben = (slot <= m_ls) && m_en[slot];
          chk("R6 sdo_oe", int'(sdo_oe), int'(ben | m_idle));
          if (!ben) chk("R6 sdo_o idle", int'(sdo_o), 0);
          m_bpos++;
          chk("R3 fs position", int'(fs_o), int'(m_bpos == (m_ls + 1) * (m_wl + 1)));
        end else if (fs_o) m_started = 1;
        if (fs_o) m_bpos = 0;
      end
      m_prev = sck_o;
    end
  end

  task automatic start_master(input int wl, input int ls, input logic [15:0] se,
                              input int dv, input logic idle);
    @(negedge clk);
    cfg_clk_master = 1'b1; cfg_fs_master = 1'b1; loop = 1'b1;
    cfg_word_len = 4'(wl); cfg_last_slot = 4'(ls); cfg_slot_en = se;
    cfg_div = 8'(dv); cfg_idle_low = idle;
    m_wl = wl; m_ls = ls; m_en = se; m_div = dv; m_idle = idle;
    repeat (3) @(negedge clk);
    en = 1'b1; mon_on = 1;
  endtask

  task automatic stop_port();
    @(negedge clk); mon_on = 0; en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sbit(input logic f, input logic b);
    @(negedge clk); sck_drv = 1'b0; fs_drv = f; sdi_drv = b;
    repeat (8) @(negedge clk);
    sck_drv = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] a [4], b [4], r, w [4];
    int base;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sck_oe", int'(sck_oe), 0);
    chk("R1 fs_oe", int'(fs_oe), 0);
    chk("R1 sdo_oe", int'(sdo_oe), 0);
    chk("R1 buf_full", int'(buf_full), 0);
    chk("R1 rx_ovf", int'(rx_ovf), 0);
    chk("R1 reg_rdata", int'(reg_rdata), 0);

    // R11: address map, receive side not writable
    wr(3'd0, 16'hBEEF);
    rd(3'd0, r); chk("R11 rx write ignored", int'(r), 0);
    a[0] = 16'hA5C3; a[1] = 16'h1234; a[2] = 16'hF00F; a[3] = 16'h8001;
    for (int i = 0; i < 4; i++) wr(3'(4 + i), a[i]);
    rd(3'd5, r); chk("R11 tx readback", int'(r), int'(a[1]));

    // directed master loopback, 8-bit words, 4 slots
    start_master(7, 3, 16'h000F, 1, 1'b0);
    @(negedge clk);
    chk("R2 sck_oe", int'(sck_oe), 1);
    wait_evt();
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), r);
      chk("R4 loopback word", int'(r), int'(keep_top(a[i], 7)));
      chk("R5 low bits zero", int'(r & 16'h00FF), 0);
    end
    b[0] = 16'h5A00; b[1] = 16'hC300; b[2] = 16'h0F00; b[3] = 16'hFF00;
    for (int i = 0; i < 4; i++) wr(3'(4 + i), b[i]);
    wait_evt();
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), r);
      chk("R8 old tx still used", int'(r), int'(keep_top(a[i], 7)));
    end
    wait_evt();
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), r);
      chk("R8 new tx used", int'(r), int'(b[i]));
    end
    wait_evt();
    chk("R9 no overflow after read", int'(rx_ovf), 0);
    wait_evt();
    @(negedge clk);
    chk("R9 overflow set", int'(rx_ovf), 1);
    stop_port();
    chk("R9 cleared by disable", int'(rx_ovf), 0);

    // idle handling: disabled middle slot, both idle modes
    for (int m = 0; m < 2; m++) begin
      start_master(5, 2, 16'h0005, 2, 1'(m));
      wait_evt();
      wait_evt();
      stop_port();
    end

    // random configurations, loopback through buffer index order
    for (int it = 0; it < 6; it++) begin
      int wl, ls, dv;
      logic [15:0] se;
      wl = 3 + int'($urandom % 13);
      ls = int'($urandom % 6);
      dv = 1 + int'($urandom % 3);
      se = 16'($urandom) & 16'((1 << (ls + 1)) - 1);
      if (se == 16'h0) se = 16'h0001;
      for (int i = 0; i < 4; i++) begin
        a[i] = 16'($urandom);
        wr(3'(4 + i), a[i]);
      end
      start_master(wl, ls, se, dv, 1'($urandom % 2));
      wait_evt();
      for (int i = 0; i < 4; i++) begin
        rd(3'(i), r);
        chk("R7 index pairing", int'(r), int'(keep_top(a[i], wl)));
      end
      stop_port();
    end

    // slave clock and sync, 16-bit words, 2 slots per frame
    @(negedge clk);
    cfg_clk_master = 1'b0; cfg_fs_master = 1'b0; loop = 1'b0;
    cfg_word_len = 4'd15; cfg_last_slot = 4'd1; cfg_slot_en = 16'h0003;
    for (int i = 0; i < 4; i++) w[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 sck_oe", int'(sck_oe), 0);
    chk("R10 fs_oe", int'(fs_oe), 0);
    base = evt_cnt;
    sbit(1'b1, 1'b0);
    for (int k = 0; k < 4; k++)
      for (int bi = 15; bi >= 0; bi--)
        sbit(1'((k == 1) && (bi == 0)), w[k][bi]);
    sbit(1'b0, 1'b0);
    sbit(1'b0, 1'b0);
    chk("R10 one group received", evt_cnt - base, 1);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), r);
      chk("R10 slave rx word", int'(r), int'(w[i]));
    end
    stop_port();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule